// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit works out where an instruction's operand lives for a 32-bit processor with eight address registers and eight data registers. An instruction decoder hands it an addressing-mode code, a register number, an operand size, the live contents of both register banks and the address of the first extension word. The unit then pulls in as many 16-bit extension words as the mode needs, one per handshake, and produces a single-cycle result.

The result carries one of three things. For a memory mode it is the operand address, with a flag that tells program (PC-relative) references apart from data references. For an immediate mode it is the assembled immediate value. For a register-direct mode it is a register tag. The result also reports how many extension words were used. The post-increment and pre-decrement modes additionally return the stepped address-register value with a write enable, for the register file to commit.

The register banks and `pcIn` must stay stable from the request until the result appears. Bus cycles, operand fetch and decode belong to other units.

Top module: `addr_gen_unit`

## Requirements
- R1: A request is accepted on a cycle where `reqValid` and `reqReady` are both high, and `reqReady` is high only while no request is in progress. `extReady` is high only while an extension word is awaited, and each cycle with `extValid` and `extReady` both high consumes one word. `resValid` pulses one cycle after the accepting edge when no words are needed, and otherwise one cycle after the edge that consumes the last word. `resExtUsed` gives the number of words consumed. Mode codes on `reqMode`: 0 data-register direct, 1 address-register direct, 2 indirect, 3 post-increment, 4 pre-decrement, 5 16-bit displacement, 6 indexed, 7 absolute short, 8 absolute long, 9 PC displacement, 10 PC indexed, 11 immediate; codes 12 to 15 behave like code 0.
- R2: Indirect mode gives the selected address register as the address, uses no extension word and does not write back.
- R3: Post-increment mode gives the address register's current value as the address. `wbData` is that value plus the step, and `wbReg` is the register number. The step is 1, 2 or 4 for `reqSize` 0 (byte), 1 (word) or 2/3 (long).
- R4: Pre-decrement mode subtracts the step from the address register, and the result is both the address and `wbData`.
- R5: For register 7 with a byte operand, both post-increment and pre-decrement use a step of 2.
- R6: Displacement mode uses one word: the address is the register plus the word sign-extended to 32 bits.
- R7: Indexed mode uses one word: the address is the register, plus the word's bits 7:0 sign-extended, plus an index register. The index register is chosen by word bit 15 (0 data bank, 1 address bank) and bits 14:12, and its full 32 bits are used.
- R8: Absolute short uses one word, sign-extended. Absolute long uses two words, with the first word forming bits 31:16.
- R9: The PC displacement and PC indexed modes form the address as in R6 and R7, but with `pcIn` (the address of the first extension word) as the base, and they set `resProg`. Every other mode leaves `resProg` low.
- R10: Immediate mode places the value on `resAddr`. A byte uses one word and zero-extends its bits 7:0. A word uses one word, zero-extended. A long uses two words, with the first word as bits 31:16.
- R11: `resReg` is {0, register} for mode 0 and {1, register} for modes 1 to 6, and 0 otherwise. Register-direct modes use no words, give address 0 and do not write back.
- R12: `wbEn` is high only together with `resValid`, and only for modes 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request may be taken |
| reqMode | input | 4 | Addressing-mode code |
| reqReg | input | 3 | Register number |
| reqSize | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| dataRegsIn | input | 256 | Data register bank, register i at bits 32i+31:32i |
| addrRegsIn | input | 256 | Address register bank, same packing |
| pcIn | input | 32 | Address of the first extension word |
| extValid | input | 1 | Extension word present |
| extReady | output | 1 | Extension word awaited |
| extWord | input | 16 | Extension word |
| resValid | output | 1 | Result pulse |
| resAddr | output | 32 | Effective address or immediate value |
| resProg | output | 1 | Program reference flag |
| resReg | output | 4 | Register tag {bank, number} |
| resExtUsed | output | 2 | Extension words consumed |
| wbEn | output | 1 | Address register write-back enable |
| wbReg | output | 3 | Write-back register number |
| wbData | output | 32 | Write-back value |

## Verification
With no extension word, every result is due on the first edge after the request is taken. Otherwise it is due on the first edge after the final word handshake, and write-back and the reference flag arrive in that same cycle. The bench drives requests and words on falling edges. It samples all result ports on the falling edge that follows the completing rising edge. One scenario holds back the extension word for several cycles, and checks that nothing is produced meanwhile and that the handshake signals show the waiting state.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;

  localparam int ADDR_W    = 32;
  localparam int EXT_W     = 16;
  localparam int NUM_REGS  = 8;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int SP_REG    = NUM_REGS - 1;
  localparam int EXT_CNT_W = 2;
  localparam int BYTE_W    = 8;

  typedef enum logic [3:0] {
    M_DREG     = 4'd0,
    M_AREG     = 4'd1,
    M_IND      = 4'd2,
    M_POSTINC  = 4'd3,
    M_PREDEC   = 4'd4,
    M_DISP     = 4'd5,
    M_INDEXED  = 4'd6,
    M_ABSSHORT = 4'd7,
    M_ABSLONG  = 4'd8,
    M_PCDISP   = 4'd9,
    M_PCINDEX  = 4'd10,
    M_IMM      = 4'd11
  } eaMode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } opSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeReq;
    logic takeW1;
    logic takeW2;
    logic finish;
  } ctlStrb_t;

  function automatic logic [EXT_CNT_W-1:0] wordsNeeded(input logic [3:0] mode,
                                                       input logic [1:0] size);
    logic [EXT_CNT_W-1:0] n;
    case (mode)
      M_DISP, M_INDEXED, M_ABSSHORT, M_PCDISP, M_PCINDEX: n = 2'd1;
      M_ABSLONG: n = 2'd2;
      M_IMM:     n = (size == SZ_BYTE || size == SZ_WORD) ? 2'd1 : 2'd2;
      default:   n = 2'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/addr_gen_ctrl.sv
module addr_gen_ctrl
  import addr_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [3:0] reqMode,
  input  logic [1:0] reqSize,
  input  logic       extValid,
  output logic       reqReady,
  output logic       extReady,
  output ctlStrb_t   strb,
  output logic       resValid
);

  typedef enum logic [1:0] {S_IDLE, S_WORD1, S_WORD2} ctlState_e;

  ctlState_e state, stateNxt;
  logic [EXT_CNT_W-1:0] needNow, needQ;

  assign needNow  = wordsNeeded(reqMode, reqSize);
  assign reqReady = (state == S_IDLE);
  assign extReady = (state != S_IDLE);

  always_comb begin
    strb.takeReq = reqValid && reqReady;
    strb.takeW1  = (state == S_WORD1) && extValid;
    strb.takeW2  = (state == S_WORD2) && extValid;
    strb.finish  = (strb.takeReq && needNow == '0) ||
                   (strb.takeW1 && needQ == 2'd1) ||
                   strb.takeW2;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:  if (strb.takeReq && needNow != '0) stateNxt = S_WORD1;
      S_WORD1: if (strb.takeW1) stateNxt = (needQ == 2'd2) ? S_WORD2 : S_IDLE;
      S_WORD2: if (strb.takeW2) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      needQ    <= '0;
      resValid <= 1'b0;
    end else begin
      state    <= stateNxt;
      resValid <= strb.finish;
      if (strb.takeReq) needQ <= needNow;
    end
  end

endmodule

// File: rtl/addr_gen_dp.sv
module addr_gen_dp
  import addr_gen_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrb_t                   strb,
  input  logic [3:0]                 reqMode,
  input  logic [REG_W-1:0]           reqReg,
  input  logic [1:0]                 reqSize,
  input  logic [NUM_REGS*ADDR_W-1:0] dataRegsIn,
  input  logic [NUM_REGS*ADDR_W-1:0] addrRegsIn,
  input  logic [ADDR_W-1:0]          pcIn,
  input  logic [EXT_W-1:0]           extWord,
  output logic [ADDR_W-1:0]          resAddr,
  output logic                       resProg,
  output logic [REG_W:0]             resReg,
  output logic [EXT_CNT_W-1:0]       resExtUsed,
  output logic                       wbEn,
  output logic [REG_W-1:0]           wbReg,
  output logic [ADDR_W-1:0]          wbData
);

  logic [ADDR_W-1:0] dReg [NUM_REGS];
  logic [ADDR_W-1:0] aReg [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign dReg[g] = dataRegsIn[g*ADDR_W +: ADDR_W];
    assign aReg[g] = addrRegsIn[g*ADDR_W +: ADDR_W];
  end

  // request fields held across the word handshakes
  logic [3:0]        modeQ;
  logic [REG_W-1:0]  regQ;
  logic [1:0]        sizeQ;
  logic [ADDR_W-1:0] pcQ;
  logic [EXT_W-1:0]  w1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      regQ  <= '0;
      sizeQ <= '0;
      pcQ   <= '0;
      w1Q   <= '0;
    end else begin
      if (strb.takeReq) begin
        modeQ <= reqMode;
        regQ  <= reqReg;
        sizeQ <= reqSize;
        pcQ   <= pcIn;
      end
      if (strb.takeW1) w1Q <= extWord;
    end
  end

  logic [3:0]        curMode;
  logic [REG_W-1:0]  curReg;
  logic [1:0]        curSize;
  logic [ADDR_W-1:0] curPc;
  logic [EXT_W-1:0]  curW1;

  assign curMode = strb.takeReq ? reqMode : modeQ;
  assign curReg  = strb.takeReq ? reqReg  : regQ;
  assign curSize = strb.takeReq ? reqSize : sizeQ;
  assign curPc   = strb.takeReq ? pcIn    : pcQ;
  assign curW1   = strb.takeW1  ? extWord : w1Q;

  logic [ADDR_W-1:0] baseA, stepVal, disp16, disp8, idxVal, wordZx, byteZx, wordPair;

  always_comb begin
    baseA    = aReg[curReg];
    disp16   = {{(ADDR_W-EXT_W){curW1[EXT_W-1]}}, curW1};
    disp8    = {{(ADDR_W-BYTE_W){curW1[BYTE_W-1]}}, curW1[BYTE_W-1:0]};
    idxVal   = curW1[EXT_W-1] ? aReg[curW1[EXT_W-1-REG_W +: REG_W]]
                              : dReg[curW1[EXT_W-1-REG_W +: REG_W]];
    wordZx   = {{(ADDR_W-EXT_W){1'b0}}, curW1};
    byteZx   = {{(ADDR_W-BYTE_W){1'b0}}, curW1[BYTE_W-1:0]};
    wordPair = {curW1, extWord};
    case (curSize)
      SZ_BYTE: stepVal = (curReg == REG_W'(SP_REG)) ? ADDR_W'(2) : ADDR_W'(1);
      SZ_WORD: stepVal = ADDR_W'(2);
      default: stepVal = ADDR_W'(4);
    endcase
  end

  logic [ADDR_W-1:0] nxtAddr, nxtWb;
  logic              nxtProg, nxtWbEn;
  logic [REG_W:0]    nxtTag;

  always_comb begin
    nxtAddr = '0;
    nxtWb   = '0;
    nxtProg = 1'b0;
    nxtWbEn = 1'b0;
    nxtTag  = '0;
    case (curMode)
      M_AREG: nxtTag = {1'b1, curReg};
      M_IND: begin
        nxtAddr = baseA;
        nxtTag  = {1'b1, curReg};
      end
      M_POSTINC: begin
        nxtAddr = baseA;
        nxtWb   = baseA + stepVal;
        nxtWbEn = 1'b1;
        nxtTag  = {1'b1, curReg};
      end
      M_PREDEC: begin
        nxtAddr = baseA - stepVal;
        nxtWb   = baseA - stepVal;
        nxtWbEn = 1'b1;
        nxtTag  = {1'b1, curReg};
      end
      M_DISP: begin
        nxtAddr = baseA + disp16;
        nxtTag  = {1'b1, curReg};
      end
      M_INDEXED: begin
        nxtAddr = baseA + disp8 + idxVal;
        nxtTag  = {1'b1, curReg};
      end
      M_ABSSHORT: nxtAddr = disp16;
      M_ABSLONG:  nxtAddr = wordPair;
      M_PCDISP: begin
        nxtAddr = curPc + disp16;
        nxtProg = 1'b1;
      end
      M_PCINDEX: begin
        nxtAddr = curPc + disp8 + idxVal;
        nxtProg = 1'b1;
      end
      M_IMM: begin
        case (curSize)
          SZ_BYTE: nxtAddr = byteZx;
          SZ_WORD: nxtAddr = wordZx;
          default: nxtAddr = wordPair;
        endcase
      end
      default: nxtTag = {1'b0, curReg};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resAddr    <= '0;
      resProg    <= 1'b0;
      resReg     <= '0;
      resExtUsed <= '0;
      wbEn       <= 1'b0;
      wbReg      <= '0;
      wbData     <= '0;
    end else if (strb.finish) begin
      resAddr    <= nxtAddr;
      resProg    <= nxtProg;
      resReg     <= nxtTag;
      resExtUsed <= wordsNeeded(curMode, curSize);
      wbEn       <= nxtWbEn;
      wbReg      <= curReg;
      wbData     <= nxtWb;
    end else begin
      resProg <= 1'b0;
      wbEn    <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import addr_gen_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [3:0]                 reqMode,
  input  logic [REG_W-1:0]           reqReg,
  input  logic [1:0]                 reqSize,
  input  logic [NUM_REGS*ADDR_W-1:0] dataRegsIn,
  input  logic [NUM_REGS*ADDR_W-1:0] addrRegsIn,
  input  logic [ADDR_W-1:0]          pcIn,
  input  logic                       extValid,
  output logic                       extReady,
  input  logic [EXT_W-1:0]           extWord,
  output logic                       resValid,
  output logic [ADDR_W-1:0]          resAddr,
  output logic                       resProg,
  output logic [REG_W:0]             resReg,
  output logic [EXT_CNT_W-1:0]       resExtUsed,
  output logic                       wbEn,
  output logic [REG_W-1:0]           wbReg,
  output logic [ADDR_W-1:0]          wbData
);

  ctlStrb_t strb;

  addr_gen_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .reqSize  (reqSize),
    .extValid (extValid),
    .reqReady (reqReady),
    .extReady (extReady),
    .strb     (strb),
    .resValid (resValid)
  );

  addr_gen_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqMode    (reqMode),
    .reqReg     (reqReg),
    .reqSize    (reqSize),
    .dataRegsIn (dataRegsIn),
    .addrRegsIn (addrRegsIn),
    .pcIn       (pcIn),
    .extWord    (extWord),
    .resAddr    (resAddr),
    .resProg    (resProg),
    .resReg     (resReg),
    .resExtUsed (resExtUsed),
    .wbEn       (wbEn),
    .wbReg      (wbReg),
    .wbData     (wbData)
  );

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk
  import addr_gen_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 extValid,
  input logic                 extReady,
  input logic                 resValid,
  input logic                 resProg,
  input logic [EXT_CNT_W-1:0] resExtUsed,
  input logic                 wbEn,
  input logic [REG_W-1:0]     wbReg,
  input logic [ADDR_W-1:0]    wbData,
  input logic [ADDR_W-1:0]    resAddr
);

  logic [2:0] wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordCnt <= '0;
    else if (reqValid && reqReady) wordCnt <= '0;
    else if (extValid && extReady) wordCnt <= wordCnt + 3'd1;
  end

  // R1
  ext_ready_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    extReady |-> !reqReady);

  // R1
  ext_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (wordCnt == {1'b0, resExtUsed}));

  // R12
  wb_with_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> resValid);

  // R9
  prog_not_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    resProg |-> (resValid && !wbEn));

  // R3
  wb_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> ((wbData == resAddr) || ((wbData - resAddr) == 32'd1) ||
              ((wbData - resAddr) == 32'd2) || ((wbData - resAddr) == 32'd4)));

  // R5
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbEn && wbReg == REG_W'(SP_REG)) |-> ((wbData - resAddr) != 32'd1));

endmodule

bind addr_gen_unit addr_gen_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .extValid   (extValid),
  .extReady   (extReady),
  .resValid   (resValid),
  .resProg    (resProg),
  .resExtUsed (resExtUsed),
  .wbEn       (wbEn),
  .wbReg      (wbReg),
  .wbData     (wbData),
  .resAddr    (resAddr)
);

// File: tb/addr_gen_unit_tb_top.sv
`timescale 1ns/1ps
module addr_gen_unit_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqMode = '0;
  logic [2:0]   reqReg = '0;
  logic [1:0]   reqSize = '0;
  logic [255:0] dataRegsIn;
  logic [255:0] addrRegsIn;
  logic [31:0]  pcIn = '0;
  logic         extValid = 1'b0;
  logic         extReady;
  logic [15:0]  extWord = '0;
  logic         resValid;
  logic [31:0]  resAddr;
  logic         resProg;
  logic [3:0]   resReg;
  logic [1:0]   resExtUsed;
  logic         wbEn;
  logic [2:0]   wbReg;
  logic [31:0]  wbData;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] aV [8];
  logic [31:0] dV [8];

  always #10 clk = ~clk;

  addr_gen_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqReg(reqReg), .reqSize(reqSize),
    .dataRegsIn(dataRegsIn), .addrRegsIn(addrRegsIn), .pcIn(pcIn),
    .extValid(extValid), .extReady(extReady), .extWord(extWord),
    .resValid(resValid), .resAddr(resAddr), .resProg(resProg),
    .resReg(resReg), .resExtUsed(resExtUsed), .wbEn(wbEn),
    .wbReg(wbReg), .wbData(wbData)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive one request and its words; returns sampled just after the completing edge
  task automatic runOp(input logic [3:0] m, input logic [2:0] r, input logic [1:0] s,
                       input int n, input logic [15:0] wa, input logic [15:0] wb);
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqReg = r; reqSize = s;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      extValid = 1'b1;
      extWord  = (k == 0) ? wa : wb;
    end
    @(negedge clk);
    reqValid = 1'b0;
    extValid = 1'b0;
  endtask

  task automatic expRes(input string req, input logic [31:0] addr, input logic prog,
                        input logic [1:0] used, input logic wen);
    chk(req, "resValid", {31'd0, resValid}, 32'd1);
    chk(req, "resAddr", resAddr, addr);
    chk(req, "resProg", {31'd0, resProg}, {31'd0, prog});
    chk(req, "resExtUsed", {30'd0, resExtUsed}, {30'd0, used});
    chk(req, "wbEn", {31'd0, wbEn}, {31'd0, wen});
  endtask

  task automatic tReset;
    chk("R1", "reset resValid", {31'd0, resValid}, 32'd0);
    chk("R1", "reset reqReady", {31'd0, reqReady}, 32'd1);
    chk("R1", "reset extReady", {31'd0, extReady}, 32'd0);
    chk("R12", "reset wbEn", {31'd0, wbEn}, 32'd0);
  endtask

  task automatic tRegDirect; // R11
    runOp(4'd0, 3'd5, 2'd2, 0, 16'h0, 16'h0);
    expRes("R11", 32'd0, 1'b0, 2'd0, 1'b0);
    chk("R11", "dreg tag", {28'd0, resReg}, 32'h5);
    runOp(4'd1, 3'd3, 2'd1, 0, 16'h0, 16'h0);
    expRes("R11", 32'd0, 1'b0, 2'd0, 1'b0);
    chk("R11", "areg tag", {28'd0, resReg}, 32'hB);
    runOp(4'd13, 3'd2, 2'd0, 0, 16'h0, 16'h0);
    chk("R1", "reserved code tag", {28'd0, resReg}, 32'h2);
  endtask

  task automatic tIndirect; // R2
    runOp(4'd2, 3'd2, 2'd2, 0, 16'h0, 16'h0);
    expRes("R2", aV[2], 1'b0, 2'd0, 1'b0);
    chk("R2", "tag", {28'd0, resReg}, 32'hA);
  endtask

  task automatic tPostInc; // R3
    runOp(4'd3, 3'd1, 2'd1, 0, 16'h0, 16'h0);
    expRes("R3", aV[1], 1'b0, 2'd0, 1'b1);
    chk("R3", "word wbData", wbData, aV[1] + 32'd2);
    chk("R3", "wbReg", {29'd0, wbReg}, 32'd1);
    runOp(4'd3, 3'd4, 2'd2, 0, 16'h0, 16'h0);
    chk("R3", "long wbData", wbData, aV[4] + 32'd4);
    runOp(4'd3, 3'd0, 2'd0, 0, 16'h0, 16'h0);
    chk("R3", "byte wbData", wbData, aV[0] + 32'd1);
    @(negedge clk);
    chk("R12", "wbEn drops", {31'd0, wbEn}, 32'd0);
  endtask

  task automatic tPreDec; // R4
    runOp(4'd4, 3'd2, 2'd2, 0, 16'h0, 16'h0);
    expRes("R4", aV[2] - 32'd4, 1'b0, 2'd0, 1'b1);
    chk("R4", "long wbData", wbData, aV[2] - 32'd4);
    runOp(4'd4, 3'd3, 2'd0, 0, 16'h0, 16'h0);
    chk("R4", "byte addr", resAddr, aV[3] - 32'd1);
    chk("R4", "byte wbData", wbData, aV[3] - 32'd1);
  endtask

  task automatic tStackByte; // R5
    runOp(4'd3, 3'd7, 2'd0, 0, 16'h0, 16'h0);
    chk("R5", "sp postinc addr", resAddr, aV[7]);
    chk("R5", "sp postinc wbData", wbData, aV[7] + 32'd2);
    runOp(4'd4, 3'd7, 2'd0, 0, 16'h0, 16'h0);
    chk("R5", "sp predec addr", resAddr, aV[7] - 32'd2);
    chk("R5", "sp predec wbData", wbData, aV[7] - 32'd2);
  endtask

  task automatic tDisp; // R6
    runOp(4'd5, 3'd1, 2'd1, 1, 16'hFFF0, 16'h0);
    expRes("R6", aV[1] - 32'd16, 1'b0, 2'd1, 1'b0);
    runOp(4'd5, 3'd6, 2'd1, 1, 16'h0100, 16'h0);
    chk("R6", "positive disp", resAddr, aV[6] + 32'h100);
  endtask

  task automatic tIndex; // R7
    runOp(4'd6, 3'd2, 2'd2, 1, 16'h30FE, 16'h0);
    expRes("R7", aV[2] - 32'd2 + dV[3], 1'b0, 2'd1, 1'b0);
    runOp(4'd6, 3'd2, 2'd2, 1, 16'hD010, 16'h0);
    chk("R7", "addr bank index", resAddr, aV[2] + 32'h10 + aV[5]);
  endtask

  task automatic tAbs; // R8
    runOp(4'd7, 3'd0, 2'd1, 1, 16'h8000, 16'h0);
    expRes("R8", 32'hFFFF8000, 1'b0, 2'd1, 1'b0);
    runOp(4'd7, 3'd0, 2'd1, 1, 16'h1234, 16'h0);
    chk("R8", "short positive", resAddr, 32'h00001234);
    runOp(4'd8, 3'd0, 2'd1, 2, 16'hDEAD, 16'hBEEF);
    expRes("R8", 32'hDEADBEEF, 1'b0, 2'd2, 1'b0);
  endtask

  task automatic tPcRel; // R9
    runOp(4'd9, 3'd0, 2'd1, 1, 16'hFFFE, 16'h0);
    expRes("R9", 32'h00004000, 1'b1, 2'd1, 1'b0);
    runOp(4'd10, 3'd0, 2'd1, 1, 16'h8004, 16'h0);
    expRes("R9", 32'h00004006 + aV[0], 1'b1, 2'd1, 1'b0);
    chk("R9", "pc tag", {28'd0, resReg}, 32'h0);
    @(negedge clk);
    chk("R9", "flag drops", {31'd0, resProg}, 32'd0);
  endtask

  task automatic tImm; // R10
    runOp(4'd11, 3'd0, 2'd0, 1, 16'h12AB, 16'h0);
    expRes("R10", 32'h000000AB, 1'b0, 2'd1, 1'b0);
    runOp(4'd11, 3'd0, 2'd1, 1, 16'h9ABC, 16'h0);
    expRes("R10", 32'h00009ABC, 1'b0, 2'd1, 1'b0);
    runOp(4'd11, 3'd0, 2'd2, 2, 16'h0123, 16'h4567);
    expRes("R10", 32'h01234567, 1'b0, 2'd2, 1'b0);
  endtask

  task automatic tStall; // R1: word held back
    @(negedge clk);
    reqValid = 1'b1; reqMode = 4'd5; reqReg = 3'd4; reqSize = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R1", "stall extReady", {31'd0, extReady}, 32'd1);
      chk("R1", "stall reqReady", {31'd0, reqReady}, 32'd0);
      chk("R1", "stall resValid", {31'd0, resValid}, 32'd0);
      @(negedge clk);
    end
    extValid = 1'b1; extWord = 16'h0008;
    @(negedge clk);
    extValid = 1'b0;
    expRes("R1", aV[4] + 32'd8, 1'b0, 2'd1, 1'b0);
    chk("R1", "idle after", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    chk("R1", "single pulse", {31'd0, resValid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      aV[i] = 32'h2000_0000 + 32'h0001_0010 * i;
      dV[i] = 32'h0000_0100 * i;
    end
    aV[7] = 32'h0000_7FF0;
    dV[3] = 32'hFFFF_FFF0;
    for (int i = 0; i < 8; i++) begin
      addrRegsIn[i*32 +: 32] = aV[i];
      dataRegsIn[i*32 +: 32] = dV[i];
    end
    pcIn = 32'h0000_4002;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tReset();
    rstN = 1'b1;
    tRegDirect();
    tIndirect();
    tPostInc();
    tPreDec();
    tStackByte();
    tDisp();
    tIndex();
    tAbs();
    tPcRel();
    tImm();
    tStall();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule